// File: doc/BRIEF.md
# USB Default Control Endpoint Status Register

This block keeps the status and command flags of the default control endpoint of a USB device function. Firmware reaches it through a byte-wide register bus: one address decode, a write strobe with write data, and a read data bus that follows the address combinationally. The USB protocol engine next to it reports link events with one-cycle strobes. These events are: packet received, IN packet transmitted, pending IN packet overwritten by an incoming SETUP or OUT packet, STALL handshake sent, control transaction ended early, and status stage completed.

The register combines three kinds of bit. Two command bits act only when written with 1 and always read 0. Two flags are set by hardware and cleared only by those commands. The remaining bits are set by software and cleared by hardware on link events, except sent-stall, which hardware sets and software clears. A registered interrupt request pulses for one cycle after each event that needs firmware attention.

Top module: `usb_ep0_ctl_reg`

## Requirements
- R1: After reset every flag is 0, so a read at the register index (parameter, default 0x11) returns 0x00 and irq is 0. Bit layout, MSB to LSB: 7 setup-end acknowledge command, 6 out-ready acknowledge command, 5 send-stall, 4 setup-end, 3 data-end, 2 sent-stall, 1 in-ready, 0 out-ready.
- R2: A write at any other address changes no flag, and a read at any other address returns 0x00.
- R3: Bits 7 and 6 always read 0. Writing 1 to bit 7 clears setup-end, and writing 1 to bit 6 clears out-ready.
- R4: Setup-end (bit 4) and out-ready (bit 0) are read-only. Writing 1 to them has no effect.
- R5: A packet-received strobe sets out-ready. Out-ready stays set until the bit 6 command clears it.
- R6: Writing 1 to bit 5 sets send-stall. A STALL-sent strobe clears it.
- R7: A STALL-sent strobe sets sent-stall. Writing 1 to bit 2 clears it.
- R8: Writing 1 to bit 1 sets in-ready. A transmitted strobe or an overwrite strobe clears it.
- R9: Writing 1 to bit 3 sets data-end. A status-done strobe clears it.
- R10: An early-end strobe sets setup-end only while data-end is 0.
- R11: Writing 0 to any bit leaves that bit unchanged.
- R12: When a set and a clear reach the same flag in the same cycle, the set wins. This covers a hardware set against a software clear and a software set against a hardware clear.
- R13: irq is high for exactly the cycle after any of these: a packet-received strobe, an early-end strobe that sets setup-end, or a transmitted or overwrite strobe while in-ready is 1. irq is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Register bus address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| ev_pkt_rx | input | 1 | Data packet received |
| ev_pkt_tx | input | 1 | IN packet transmitted |
| ev_in_overwrite | input | 1 | SETUP or OUT packet overwrote the pending IN packet |
| ev_stall_tx | input | 1 | STALL handshake sent |
| ev_early_end | input | 1 | Control transaction ended early |
| ev_status_done | input | 1 | Status stage completed |
| irq | output | 1 | Interrupt request pulse |

## Verification
A firmware write and a protocol-engine strobe can reach the same flag in one cycle. Examples are an out-ready acknowledge arriving together with a new packet-received strobe, and a fresh in-ready set arriving together with a transmitted strobe. The bench drives the write and the strobe in the same cycle. It then reads the register back and checks the irq pulse. In every case the setting side must win, and irq must still report the hardware event.

// File: rtl/ep0_reg_pkg.sv
package ep0_reg_pkg;
  localparam int REG_W  = 8;
  localparam int NFLAGS = 6;

  // flag positions equal their bit positions in the register
  localparam int F_OUT_RDY    = 0;
  localparam int F_IN_RDY     = 1;
  localparam int F_SENT_STALL = 2;
  localparam int F_DATA_END   = 3;
  localparam int F_SETUP_END  = 4;
  localparam int F_SEND_STALL = 5;

  // command-only positions
  localparam int C_ACK_OUT   = 6;
  localparam int C_ACK_SETUP = 7;

  typedef logic [NFLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/ep0_flag_cell.sv
module ep0_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/ep0_bus_dec.sv
module ep0_bus_dec
  import ep0_reg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned REG_INDEX = 'h11
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  flag_vec_t         flags_i,
  output flag_vec_t         sw_set_o,
  output flag_vec_t         sw_clr_o,
  output logic [REG_W-1:0]  rdata_o
);
  localparam logic [ADDR_W-1:0] IDX = REG_INDEX[ADDR_W-1:0];

  logic hit;
  logic hit_wr;
  logic unused_ro_bits;

  assign hit    = (addr_i == IDX);
  assign hit_wr = hit & wr_i;

  // writes to the read-only flag positions are dropped
  assign unused_ro_bits = ^{wdata_i[F_SETUP_END], wdata_i[F_OUT_RDY]};

  always_comb begin
    sw_set_o = '0;
    sw_clr_o = '0;
    if (hit_wr) begin
      sw_set_o[F_SEND_STALL] = wdata_i[F_SEND_STALL];
      sw_set_o[F_DATA_END]   = wdata_i[F_DATA_END];
      sw_set_o[F_IN_RDY]     = wdata_i[F_IN_RDY];
      sw_clr_o[F_SETUP_END]  = wdata_i[C_ACK_SETUP];
      sw_clr_o[F_OUT_RDY]    = wdata_i[C_ACK_OUT];
      sw_clr_o[F_SENT_STALL] = wdata_i[F_SENT_STALL];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit) rdata_o[NFLAGS-1:0] = flags_i;
  end
endmodule

// File: rtl/ep0_hw_events.sv
module ep0_hw_events
  import ep0_reg_pkg::*;
(
  input  logic      ev_pkt_rx_i,
  input  logic      ev_pkt_tx_i,
  input  logic      ev_in_overwrite_i,
  input  logic      ev_stall_tx_i,
  input  logic      ev_early_end_i,
  input  logic      ev_status_done_i,
  input  flag_vec_t flags_i,
  output flag_vec_t hw_set_o,
  output flag_vec_t hw_clr_o,
  output logic      irq_req_o
);
  logic in_drop;

  assign in_drop = ev_pkt_tx_i | ev_in_overwrite_i;

  always_comb begin
    hw_set_o = '0;
    hw_clr_o = '0;
    hw_set_o[F_OUT_RDY]    = ev_pkt_rx_i;
    hw_set_o[F_SENT_STALL] = ev_stall_tx_i;
    hw_set_o[F_SETUP_END]  = ev_early_end_i & ~flags_i[F_DATA_END];
    hw_clr_o[F_IN_RDY]     = in_drop;
    hw_clr_o[F_SEND_STALL] = ev_stall_tx_i;
    hw_clr_o[F_DATA_END]   = ev_status_done_i;
  end

  assign irq_req_o = hw_set_o[F_OUT_RDY] | hw_set_o[F_SETUP_END]
                   | (in_drop & flags_i[F_IN_RDY]);
endmodule

// File: rtl/ep0_irq_gen.sv
module ep0_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= req_i;
  end
endmodule

// File: rtl/usb_ep0_ctl_reg.sv
module usb_ep0_ctl_reg
  import ep0_reg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned REG_INDEX = 'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              ev_pkt_rx,
  input  logic              ev_pkt_tx,
  input  logic              ev_in_overwrite,
  input  logic              ev_stall_tx,
  input  logic              ev_early_end,
  input  logic              ev_status_done,
  output logic              irq
);
  flag_vec_t flags_q;
  flag_vec_t sw_set, sw_clr, hw_set, hw_clr;
  logic      irq_req;

  ep0_bus_dec #(.ADDR_W(ADDR_W), .REG_INDEX(REG_INDEX)) u_bus (
    .addr_i(reg_addr), .wr_i(reg_wr), .wdata_i(reg_wdata), .flags_i(flags_q),
    .sw_set_o(sw_set), .sw_clr_o(sw_clr), .rdata_o(reg_rdata)
  );

  ep0_hw_events u_hw (
    .ev_pkt_rx_i(ev_pkt_rx), .ev_pkt_tx_i(ev_pkt_tx),
    .ev_in_overwrite_i(ev_in_overwrite), .ev_stall_tx_i(ev_stall_tx),
    .ev_early_end_i(ev_early_end), .ev_status_done_i(ev_status_done),
    .flags_i(flags_q), .hw_set_o(hw_set), .hw_clr_o(hw_clr),
    .irq_req_o(irq_req)
  );

  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    ep0_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .set_i(sw_set[i] | hw_set[i]),
      .clr_i(sw_clr[i] | hw_clr[i]),
      .q_o(flags_q[i])
    );
  end

  ep0_irq_gen u_irq (.clk(clk), .rst_n(rst_n), .req_i(irq_req), .irq_o(irq));
endmodule

// File: rtl/ep0_ctl_reg_chk.sv
module ep0_ctl_reg_chk #(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned REG_INDEX = 'h11
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic              ev_pkt_rx,
  input logic              ev_pkt_tx,
  input logic              ev_in_overwrite,
  input logic              ev_stall_tx,
  input logic              ev_early_end,
  input logic [5:0]        flags,
  input logic              irq
);
  logic hit_wr;
  assign hit_wr = reg_wr && (reg_addr == REG_INDEX[ADDR_W-1:0]);

  a_r3_cmd_bits_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:6] == 2'b00);

  a_r2_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != REG_INDEX[ADDR_W-1:0]) |-> reg_rdata == 8'h00);

  a_r5_rx_sets_out_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pkt_rx |=> flags[0] && irq);

  a_r5_out_rdy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !(hit_wr && reg_wdata[6])) |=> flags[0]);

  a_r7_stall_tx_sets_sent: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stall_tx |=> flags[2]);

  a_r6_stall_tx_drops_send: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stall_tx && !(hit_wr && reg_wdata[5])) |=> !flags[5]);

  a_r10_setup_end_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[4]) |-> $past(ev_early_end && !flags[3]));

  a_r13_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ev_pkt_rx || ev_early_end || ev_pkt_tx || ev_in_overwrite));
endmodule

bind usb_ep0_ctl_reg ep0_ctl_reg_chk #(.ADDR_W(ADDR_W), .REG_INDEX(REG_INDEX)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_pkt_rx(ev_pkt_rx),
  .ev_pkt_tx(ev_pkt_tx), .ev_in_overwrite(ev_in_overwrite),
  .ev_stall_tx(ev_stall_tx), .ev_early_end(ev_early_end),
  .flags(flags_q), .irq(irq)
);

// File: tb/usb_ep0_ctl_reg_tb_top.sv
`timescale 1ns/1ps
module usb_ep0_ctl_reg_tb_top;
  localparam int AW = 6;
  localparam logic [AW-1:0] IDX = 6'h11;

  // event vector bits: 0 rx, 1 tx, 2 overwrite, 3 stall_tx, 4 early_end, 5 status_done
  localparam logic [5:0] E_RX = 6'h01, E_TX = 6'h02, E_OVW = 6'h04,
                         E_STL = 6'h08, E_EARLY = 6'h10, E_STAT = 6'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] reg_addr = IDX;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [5:0] ev = '0;
  logic irq;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  usb_ep0_ctl_reg #(.ADDR_W(AW), .REG_INDEX('h11)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_pkt_rx(ev[0]), .ev_pkt_tx(ev[1]), .ev_in_overwrite(ev[2]),
    .ev_stall_tx(ev[3]), .ev_early_end(ev[4]), .ev_status_done(ev[5]),
    .irq(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; afterwards rdata shows the updated flags and irq its pulse
  task automatic step(logic wr, logic [7:0] d, logic [5:0] e);
    @(negedge clk);
    reg_wr = wr; reg_wdata = d; ev = e;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00; ev = '0;
  endtask

  task automatic t_reset;
    chk("R1 reset value", reg_rdata, 8'h00);
    chk("R1 reset irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_cmd_and_ro;
    step(1'b1, 8'hC0, '0);
    chk("R3 command bits read zero", reg_rdata, 8'h00);
    step(1'b1, 8'h11, '0);
    chk("R4 read-only bits ignore writes", reg_rdata, 8'h00);
  endtask

  task automatic t_out_rdy;
    step(1'b0, 8'h00, E_RX);
    chk("R5 out-ready set", reg_rdata, 8'h01);
    chk("R13 irq on rx", {7'd0, irq}, 8'h01);
    @(negedge clk);
    chk("R13 irq one cycle", {7'd0, irq}, 8'h00);
    step(1'b1, 8'h01, '0);
    chk("R5 out-ready held", reg_rdata, 8'h01);
    step(1'b1, 8'h40, '0);
    chk("R3 ack clears out-ready", reg_rdata, 8'h00);
  endtask

  task automatic t_in_rdy;
    step(1'b1, 8'h02, '0);
    chk("R8 in-ready set", reg_rdata, 8'h02);
    chk("R13 no irq on write", {7'd0, irq}, 8'h00);
    step(1'b0, 8'h00, E_TX);
    chk("R8 tx clears in-ready", reg_rdata, 8'h00);
    chk("R13 irq on tx", {7'd0, irq}, 8'h01);
    step(1'b1, 8'h02, '0);
    step(1'b0, 8'h00, E_OVW);
    chk("R8 overwrite clears in-ready", reg_rdata, 8'h00);
    chk("R13 irq on overwrite", {7'd0, irq}, 8'h01);
    step(1'b0, 8'h00, E_TX);
    chk("R13 no irq when in-ready idle", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_stall;
    step(1'b1, 8'h20, '0);
    chk("R6 send-stall set", reg_rdata, 8'h20);
    step(1'b0, 8'h00, E_STL);
    chk("R7 stall swaps flags", reg_rdata, 8'h04);
    chk("R13 no irq on stall", {7'd0, irq}, 8'h00);
    step(1'b1, 8'h00, '0);
    chk("R11 zero write keeps sent-stall", reg_rdata, 8'h04);
    step(1'b1, 8'h04, '0);
    chk("R7 sent-stall cleared", reg_rdata, 8'h00);
  endtask

  task automatic t_data_setup_end;
    step(1'b1, 8'h08, '0);
    chk("R9 data-end set", reg_rdata, 8'h08);
    step(1'b0, 8'h00, E_EARLY);
    chk("R10 early end masked by data-end", reg_rdata, 8'h08);
    chk("R13 no irq when masked", {7'd0, irq}, 8'h00);
    step(1'b0, 8'h00, E_STAT);
    chk("R9 status done clears data-end", reg_rdata, 8'h00);
    step(1'b0, 8'h00, E_EARLY);
    chk("R10 setup-end set", reg_rdata, 8'h10);
    chk("R13 irq on setup-end", {7'd0, irq}, 8'h01);
    step(1'b1, 8'h80, '0);
    chk("R3 ack clears setup-end", reg_rdata, 8'h00);
  endtask

  task automatic t_addr_miss;
    reg_addr = 6'h22;
    step(1'b1, 8'h2A, '0);
    chk("R2 miss reads zero", reg_rdata, 8'h00);
    reg_addr = IDX;
    #0.1;
    chk("R2 miss write ignored", reg_rdata, 8'h00);
  endtask

  task automatic t_collide;
    step(1'b0, 8'h00, E_RX);
    step(1'b1, 8'h40, E_RX);
    chk("R12 rx beats out-ready ack", reg_rdata, 8'h01);
    chk("R12 irq on collided rx", {7'd0, irq}, 8'h01);
    step(1'b1, 8'h40, '0);
    step(1'b1, 8'h02, '0);
    step(1'b1, 8'h02, E_TX);
    chk("R12 in-ready set beats tx clear", reg_rdata, 8'h02);
    chk("R12 irq on collided tx", {7'd0, irq}, 8'h01);
    step(1'b0, 8'h00, E_TX);
    step(1'b1, 8'h24, E_STL);
    chk("R12 sent-stall and send-stall both set", reg_rdata, 8'h24);
    step(1'b1, 8'h04, E_STL);
    chk("R12 stall event beats sent-stall clear", reg_rdata, 8'h04);
    step(1'b1, 8'h04, '0);
    step(1'b1, 8'h08, E_STAT);
    chk("R12 data-end set beats status clear", reg_rdata, 8'h08);
    step(1'b0, 8'h00, E_STAT);
    chk("R9 cleanup", reg_rdata, 8'h00);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmd_and_ro();
    t_out_rdy();
    t_in_rdy();
    t_stall();
    t_data_setup_end();
    t_addr_miss();
    t_collide();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule